// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is an 8-bit serial port for the SPI family of buses. One 4-bit mode field selects the role. The port can be a bus master with one of four bit-clock sources. It can be a slave that uses its select pin, or a slave that ignores that pin. Three further control bits set how the port behaves on the wire. The idle-clock level is one. A clock-edge bit picks the phase; it is inverted with respect to the common phase convention. A sample-point bit picks when the master captures its input.

Software starts a transfer by writing a byte. When all eight bits have been exchanged, the port places the received byte in a one-deep receive buffer and raises a completion flag. A write made during a transfer is refused and flagged as a collision. A byte that completes while the buffer still holds an unread byte is dropped and flagged as an overflow. A clock-enable input freezes the master engine mid-byte, and the transfer resumes exactly where it stopped. The slave engine does not depend on this enable, so a byte can arrive while the enable is low. Reset, or disabling the port, aborts any transfer.

Top module: `xsp_port`

## Requirements
- R1: With the phase bit set to 1, data leaves on the trailing edge and is captured on the leading edge. With it set to 0, data leaves on the leading edge and is captured on the trailing edge. The four (idle level, phase bit) pairs (0,1), (0,0), (1,1), (1,0) are bus modes 0, 1, 2 and 3.
- R2: Between bytes the master holds `sck_out` at `cfg_pol`. Each byte makes exactly 16 clock transitions.
- R3: Data moves most significant bit first, on `sdo` and on `sdi`.
- R4: With `cfg_smp`=0 the master captures `sdi` at the middle of each bit time. With `cfg_smp`=1 it captures `sdi` at the end of each bit time.
- R5: `cfg_mode` values 0000, 0001 and 0010 give a bit clock of the system clock /4, /16 and /64. A byte then takes 32, 128 or 512 cycles. Value 0011 uses one `tmr_tick` pulse per clock half, so a byte takes 16 pulses.
- R6: `done_flag` rises only once the eighth bit has been shifted in. It stays set until `flag_clr`.
- R7: In slave mode (`cfg_mode`=0101), a byte clocked in on `sck_in` is received, and `done_flag` sets, even while `clk_en` is low.
- R8: With `cfg_mode`=0100, clock edges are ignored while `sel_n` is high. With `cfg_mode`=0101, `sel_n` is ignored.
- R9: While `clk_en` is low, a master transfer holds its bit position, shift contents and clock level. When `clk_en` returns, the transfer completes with correct data.
- R10: Reset aborts a transfer. It leaves the port idle, with `sck_out` at `cfg_pol`, no flags set and an empty buffer.
- R11: A write made while `busy` is high sets `wcol_flag`. The byte being sent is not altered.
- R12: A byte that completes while `rx_valid` is high sets `ovf_flag`. `rx_data` keeps the older byte.
- R13: With `port_en` low, or with `cfg_mode` at 0110 or above, the port is off. It aborts any transfer and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| clk_en | input | 1 | module clock enable; low freezes the master engine |
| port_en | input | 1 | port enable |
| cfg_pol | input | 1 | clock idle level |
| cfg_edge | input | 1 | clock-edge (phase) select, see R1 |
| cfg_smp | input | 1 | master sample point: 0 middle, 1 end |
| cfg_mode | input | 4 | role and rate select |
| tmr_tick | input | 1 | shared external timer tick |
| wr_en | input | 1 | write strobe for the transmit byte |
| wr_data | input | 8 | byte to transmit |
| rd_en | input | 1 | read strobe; empties the receive buffer |
| flag_clr | input | 1 | clears the done, collision and overflow flags |
| sck_in | input | 1 | serial clock in slave mode |
| sel_n | input | 1 | slave select, active low |
| sdi | input | 1 | serial data in |
| sck_out | output | 1 | serial clock driven in master mode |
| sck_drive | output | 1 | high when the port drives the serial clock |
| sdo | output | 1 | serial data out |
| busy | output | 1 | a transfer is in progress |
| rx_data | output | 8 | receive buffer |
| rx_valid | output | 1 | receive buffer holds an unread byte |
| done_flag | output | 1 | byte-complete flag |
| wcol_flag | output | 1 | write-collision flag |
| ovf_flag | output | 1 | receive-overflow flag |

## Verification
The bench contains a bus slave. It can drive its answer at the start of each bit or half a bit late, so the two sample points give different bytes. A design that swapped the sample point, inverted the phase sense, or shifted least significant bit first would return a wrong byte or capture the wrong output bits. The bench counts cycles per byte for every rate. It counts timer pulses against the completion point, so a wrong divider or an off-by-one half count shows. It also stalls the enable mid-byte, resets mid-byte, overruns the buffer, collides a write, and feeds a slave byte with the enable off. Each of these targets a design that would lose state, corrupt data, or raise the flag early.

// File: rtl/xsp_pkg.sv
package xsp_pkg;

    typedef enum logic [1:0] {
        SRC_DIV_A = 2'd0,
        SRC_DIV_B = 2'd1,
        SRC_DIV_C = 2'd2,
        SRC_TICK  = 2'd3
    } rate_src_e;

    typedef enum logic [1:0] {
        ROLE_OFF,
        ROLE_MASTER,
        ROLE_SLAVE_SEL,
        ROLE_SLAVE_FREE
    } role_e;

    function automatic role_e decode_role(input logic [3:0] mode);
        if (mode[3:2] == 2'b00)  return ROLE_MASTER;
        else if (mode == 4'b0100) return ROLE_SLAVE_SEL;
        else if (mode == 4'b0101) return ROLE_SLAVE_FREE;
        else                      return ROLE_OFF;
    endfunction

endpackage

// File: rtl/xsp_rate_gen.sv
module xsp_rate_gen import xsp_pkg::*; #(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      clk_en,
    input  logic      tmr_tick,
    input  rate_src_e src,
    output logic      half_tick
);
    localparam int CW = $clog2(DIV_C / 2) + 1;

    logic [CW-1:0] cnt_q, cnt_d, lim;

    always_comb begin
        case (src)
            SRC_DIV_A: lim = CW'(DIV_A / 2 - 1);
            SRC_DIV_B: lim = CW'(DIV_B / 2 - 1);
            SRC_DIV_C: lim = CW'(DIV_C / 2 - 1);
            default:   lim = '0;
        endcase
        if (src == SRC_TICK) half_tick = run && clk_en && tmr_tick;
        else                 half_tick = run && clk_en && (cnt_q == lim);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (clk_en && (src != SRC_TICK))
            cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/xsp_master.sv
module xsp_master #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         half_tick,
    input  logic         pol,
    input  logic         cpha1,
    input  logic         smp_late,
    input  logic         sdi,
    output logic         busy,
    output logic         sck,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int HW = $clog2(2 * W);
    localparam logic [HW-1:0] LAST = HW'(2 * W - 1);

    typedef struct packed {
        logic          busy;
        logic [HW-1:0] half;
        logic [W-1:0]  shreg;
        logic          mid;
    } mst_t;

    mst_t q, d;
    logic in_bit;

    always_comb begin
        d       = q;
        done    = 1'b0;
        in_bit  = smp_late ? sdi : q.mid;
        rx_byte = {q.shreg[W-2:0], in_bit};
        if (abort) begin
            d = '0;
        end else if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.half  = '0;
                d.shreg = tx_byte;
            end
        end else if (half_tick) begin
            d.half = q.half + 1'b1;
            if (!q.half[0]) begin
                d.mid = sdi;
            end else begin
                d.shreg = rx_byte;
                if (q.half == LAST) begin
                    d.busy = 1'b0;
                    d.half = '0;
                    done   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign sdo  = q.shreg[W-1];
    assign sck  = q.busy ? (pol ^ (cpha1 ? ~q.half[0] : q.half[0])) : pol;

endmodule

// File: rtl/xsp_slave.sv
module xsp_slave #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         use_sel,
    input  logic         pol,
    input  logic         cpha1,
    input  logic         sck_in,
    input  logic         sel_n,
    input  logic         sdi,
    input  logic         load,
    input  logic [W-1:0] tx_byte,
    output logic         busy,
    output logic         sdo,
    output logic         done,
    output logic [W-1:0] rx_byte
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LASTC = CW'(W - 1);

    typedef struct packed {
        logic          s_meta;
        logic          s_sync;
        logic          s_prev;
        logic          n_meta;
        logic          n_sync;
        logic [CW-1:0] cnt;
        logic [W-1:0]  shreg;
    } slv_t;

    slv_t q, d;
    logic toggled, lead, trail, take, blocked;

    always_comb begin
        d        = q;
        done     = 1'b0;
        rx_byte  = {q.shreg[W-2:0], sdi};
        d.s_meta = sck_in;
        d.s_sync = q.s_meta;
        d.s_prev = q.s_sync;
        d.n_meta = sel_n;
        d.n_sync = q.n_meta;
        toggled  = q.s_sync != q.s_prev;
        lead     = toggled && (q.s_prev == pol);
        trail    = toggled && (q.s_prev != pol);
        take     = cpha1 ? trail : lead;
        blocked  = use_sel && q.n_sync;
        if (!active || blocked) begin
            d.cnt = '0;
        end else if (take) begin
            d.shreg = rx_byte;
            if (q.cnt == LASTC) begin
                d.cnt = '0;
                done  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (active && load) d.shreg = tx_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.n_meta <= 1'b1;
            q.n_sync <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = q.cnt != '0;
    assign sdo  = q.shreg[W-1];

endmodule

// File: rtl/xsp_port.sv
module xsp_port import xsp_pkg::*; #(
    parameter int W     = 8,
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_en,
    input  logic         port_en,
    input  logic         cfg_pol,
    input  logic         cfg_edge,
    input  logic         cfg_smp,
    input  logic [3:0]   cfg_mode,
    input  logic         tmr_tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         flag_clr,
    input  logic         sck_in,
    input  logic         sel_n,
    input  logic         sdi,
    output logic         sck_out,
    output logic         sck_drive,
    output logic         sdo,
    output logic         busy,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         done_flag,
    output logic         wcol_flag,
    output logic         ovf_flag
);
    typedef struct packed {
        logic [W-1:0] rx_buf;
        logic         rx_full;
        logic         done;
        logic         wcol;
        logic         ovf;
    } top_t;

    top_t  q, d;
    role_e role;
    logic  is_master, is_slave, cpha1, eng_busy, start, half_tick, fin;
    logic  m_busy, m_sck, m_sdo, m_done, s_busy, s_sdo, s_done;
    logic [W-1:0] m_rx, s_rx, new_byte;

    assign role      = port_en ? decode_role(cfg_mode) : ROLE_OFF;
    assign is_master = role == ROLE_MASTER;
    assign is_slave  = (role == ROLE_SLAVE_SEL) || (role == ROLE_SLAVE_FREE);
    assign cpha1     = ~cfg_edge;
    assign eng_busy  = m_busy | s_busy;
    assign start     = wr_en && !eng_busy && (is_master || is_slave);
    assign fin       = m_done | s_done;
    assign new_byte  = m_done ? m_rx : s_rx;

    xsp_rate_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(m_busy), .clk_en(clk_en),
        .tmr_tick(tmr_tick), .src(rate_src_e'(cfg_mode[1:0])), .half_tick(half_tick)
    );

    xsp_master #(.W(W)) u_mst (
        .clk(clk), .rst_n(rst_n), .abort(!is_master), .start(start && is_master),
        .tx_byte(wr_data), .half_tick(half_tick), .pol(cfg_pol), .cpha1(cpha1),
        .smp_late(cfg_smp), .sdi(sdi), .busy(m_busy), .sck(m_sck), .sdo(m_sdo),
        .done(m_done), .rx_byte(m_rx)
    );

    xsp_slave #(.W(W)) u_slv (
        .clk(clk), .rst_n(rst_n), .active(is_slave), .use_sel(role == ROLE_SLAVE_SEL),
        .pol(cfg_pol), .cpha1(cpha1), .sck_in(sck_in), .sel_n(sel_n), .sdi(sdi),
        .load(start && is_slave), .tx_byte(wr_data), .busy(s_busy), .sdo(s_sdo),
        .done(s_done), .rx_byte(s_rx)
    );

    always_comb begin
        d = q;
        if (rd_en) d.rx_full = 1'b0;
        if (flag_clr) begin
            d.done = 1'b0;
            d.wcol = 1'b0;
            d.ovf  = 1'b0;
        end
        if (wr_en && eng_busy && (role != ROLE_OFF)) d.wcol = 1'b1;
        if (fin) begin
            d.done = 1'b1;
            if (q.rx_full && !rd_en) begin
                d.ovf = 1'b1;
            end else begin
                d.rx_buf  = new_byte;
                d.rx_full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck_out   = is_master ? m_sck : cfg_pol;
    assign sck_drive = is_master;
    assign sdo       = is_master ? m_sdo : (is_slave ? s_sdo : 1'b0);
    assign busy      = eng_busy;
    assign rx_data   = q.rx_buf;
    assign rx_valid  = q.rx_full;
    assign done_flag = q.done;
    assign wcol_flag = q.wcol;
    assign ovf_flag  = q.ovf;

endmodule

// File: rtl/xsp_port_chk.sv
module xsp_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clk_en,
    input logic         port_en,
    input logic         cfg_pol,
    input logic         cfg_edge,
    input logic         wr_en,
    input logic         sck_out,
    input logic         sck_drive,
    input logic         sdo,
    input logic         busy,
    input logic [W-1:0] rx_data,
    input logic         done_flag,
    input logic         wcol_flag,
    input logic         ovf_flag
);
    assert_idle_sck_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_drive && !busy) |-> (sck_out == cfg_pol));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_drive && busy && !clk_en) |=>
            (!sck_drive || (cfg_pol != $past(cfg_pol)) || (cfg_edge != $past(cfg_edge)) ||
             (busy && (sck_out == $past(sck_out)) && (sdo == $past(sdo)))));

    assert_wcol_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && port_en) |=> wcol_flag);

    assert_ovf_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $stable(rx_data));

    assert_done_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy));

    assert_off_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !busy);

endmodule

bind xsp_port xsp_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
    .cfg_pol(cfg_pol), .cfg_edge(cfg_edge), .wr_en(wr_en),
    .sck_out(sck_out), .sck_drive(sck_drive), .sdo(sdo), .busy(busy),
    .rx_data(rx_data), .done_flag(done_flag), .wcol_flag(wcol_flag), .ovf_flag(ovf_flag)
);

// File: tb/xsp_port_bench.sv
`timescale 1ns/1ps
module xsp_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_en = 1'b1, port_en = 1'b1, cfg_pol = 1'b0, cfg_edge = 1'b1, cfg_smp = 1'b0;
    logic [3:0] cfg_mode = 4'b0000;
    logic tmr_tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, flag_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic sck_in = 1'b0, sel_n = 1'b0, sdi_b = 1'b0;
    logic sck_out, sck_drive, sdo, busy, rx_valid, done_flag, wcol_flag, ovf_flag;
    logic [7:0] rx_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    xsp_port u_xsp_port (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
        .cfg_pol(cfg_pol), .cfg_edge(cfg_edge), .cfg_smp(cfg_smp), .cfg_mode(cfg_mode),
        .tmr_tick(tmr_tick), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .flag_clr(flag_clr), .sck_in(sck_in), .sel_n(sel_n), .sdi(sdi_b),
        .sck_out(sck_out), .sck_drive(sck_drive), .sdo(sdo), .busy(busy),
        .rx_data(rx_data), .rx_valid(rx_valid), .done_flag(done_flag),
        .wcol_flag(wcol_flag), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bench bus slave driven by the port's serial clock
    logic bs_on = 1'b0, bs_late = 1'b0, bs_cpha1 = 1'b0;
    logic [7:0] bs_tx = 8'h00, bs_rx = 8'h00;
    int bs_edges = 0;
    int bs_b;

    always @(sck_out) begin
        if (bs_on) begin
            bs_b = bs_edges + (bs_cpha1 ? 0 : 1);
            if (bs_b % 2 == 1) bs_rx = {bs_rx[6:0], sdo};
            if (bs_late) begin
                if ((bs_b % 2 == 1) && ((bs_b - 1) / 2 < 8)) sdi_b = bs_tx[7 - (bs_b - 1) / 2];
            end else begin
                if ((bs_b % 2 == 0) && (bs_b / 2 < 8)) sdi_b = bs_tx[7 - bs_b / 2];
            end
            bs_edges++;
        end
    end

    // scoreboard monitor: every newly buffered byte is compared with the queue head
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n && rx_valid && !prev_valid) begin
            if (exp_q.size() == 0) chk("R3 scoreboard unexpected byte", {24'h0, rx_data}, 32'hFFFF);
            else chk("R3 scoreboard rx byte", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
        end
        prev_valid = rx_valid;
    end

    task automatic bs_arm(input logic [7:0] sl, input logic late);
        bs_tx    = sl;
        bs_late  = late;
        bs_cpha1 = ~cfg_edge;
        bs_rx    = 8'h00;
        bs_edges = 0;
        sdi_b    = late ? ~sl[7] : sl[7];
        bs_on    = 1'b1;
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_data = b;
        wr_en   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        rd_en    = 1'b1;
        flag_clr = 1'b1;
        @(negedge clk);
        rd_en    = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sl, input logic late,
                               input logic push, input logic [7:0] exp_rx, output int cyc);
        bs_arm(sl, late);
        if (push) exp_q.push_back(exp_rx);
        write_byte(tx);
        cyc = 0;
        while (busy) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        bs_on = 1'b0;
    endtask

    task automatic slave_bits(input logic [7:0] b, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            @(negedge clk);
            sdi_b = b[7 - i];
            repeat (4) @(negedge clk);
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
            sck_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        logic held_sck, held_sdo;
        repeat (4) @(negedge clk);
        chk("R10 reset busy", busy, 0);
        chk("R10 reset done", done_flag, 0);
        chk("R10 reset rx_valid", rx_valid, 0);
        chk("R10 reset sck idle", sck_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // mode 0, div 4
        master_xfer(8'hA5, 8'h3C, 1'b0, 1'b1, 8'h3C, cyc);
        chk("R5 div4 cycles", cyc, 32);
        chk("R3 mosi byte mode0", bs_rx, 8'hA5);
        chk("R2 edges per byte", bs_edges, 16);
        chk("R2 idle level", sck_out, 0);
        chk("R6 done set", done_flag, 1);
        clear_all();

        // mode 1, div 16
        cfg_edge = 1'b0; cfg_mode = 4'b0001;
        master_xfer(8'h96, 8'hC3, 1'b0, 1'b1, 8'hC3, cyc);
        chk("R5 div16 cycles", cyc, 128);
        chk("R1 mosi byte mode1", bs_rx, 8'h96);
        clear_all();

        // mode 2, div 64
        cfg_pol = 1'b1; cfg_edge = 1'b1; cfg_mode = 4'b0010;
        repeat (2) @(negedge clk);
        master_xfer(8'h0F, 8'hF0, 1'b0, 1'b1, 8'hF0, cyc);
        chk("R5 div64 cycles", cyc, 512);
        chk("R1 mosi byte mode2", bs_rx, 8'h0F);
        chk("R2 idle level pol1", sck_out, 1);
        clear_all();

        // mode 3, late slave, end sampling
        cfg_edge = 1'b0; cfg_mode = 4'b0000; cfg_smp = 1'b1;
        master_xfer(8'h5A, 8'h81, 1'b1, 1'b1, 8'h81, cyc);
        chk("R1 mosi byte mode3", bs_rx, 8'h5A);
        chk("R2 edges mode3", bs_edges, 16);
        clear_all();

        // mode 0, late slave, middle sampling sees previous bit
        cfg_pol = 1'b0; cfg_edge = 1'b1; cfg_smp = 1'b0;
        repeat (2) @(negedge clk);
        master_xfer(8'h12, 8'hB6, 1'b1, 1'b1, 8'h5B, cyc);
        chk("R4 mid sample mosi", bs_rx, 8'h12);
        clear_all();

        // timer tick time base
        cfg_mode = 4'b0011;
        bs_arm(8'h11, 1'b0);
        exp_q.push_back(8'h11);
        write_byte(8'h77);
        for (int t = 0; t < 16; t++) begin
            if (t == 15) chk("R5 tick busy before last", busy, 1);
            repeat (2) @(negedge clk);
            tmr_tick = 1'b1;
            @(negedge clk);
            tmr_tick = 1'b0;
        end
        chk("R5 tick busy after 16", busy, 0);
        bs_on = 1'b0;
        chk("R5 tick mosi", bs_rx, 8'h77);
        clear_all();

        // write collision
        cfg_mode = 4'b0001;
        bs_arm(8'h6E, 1'b0);
        exp_q.push_back(8'h6E);
        write_byte(8'h3E);
        repeat (20) @(negedge clk);
        write_byte(8'h99);
        chk("R11 wcol set", wcol_flag, 1);
        while (busy) @(negedge clk);
        bs_on = 1'b0;
        chk("R11 byte unchanged", bs_rx, 8'h3E);
        clear_all();
        chk("R11 wcol cleared", wcol_flag, 0);

        // overflow
        master_xfer(8'h01, 8'h44, 1'b0, 1'b1, 8'h44, cyc);
        master_xfer(8'h02, 8'h55, 1'b0, 1'b0, 8'h00, cyc);
        chk("R12 ovf set", ovf_flag, 1);
        chk("R12 buffer keeps old", rx_data, 8'h44);
        clear_all();

        // freeze and resume
        bs_arm(8'h2D, 1'b0);
        exp_q.push_back(8'h2D);
        write_byte(8'hC8);
        repeat (30) @(negedge clk);
        clk_en   = 1'b0;
        @(negedge clk);
        held_sck = sck_out;
        held_sdo = sdo;
        repeat (60) @(negedge clk);
        chk("R9 frozen busy", busy, 1);
        chk("R9 frozen sck", sck_out, held_sck);
        chk("R9 frozen sdo", sdo, held_sdo);
        clk_en = 1'b1;
        while (busy) @(negedge clk);
        bs_on = 1'b0;
        chk("R9 resumed mosi", bs_rx, 8'hC8);
        chk("R9 resumed edges", bs_edges, 16);
        clear_all();

        // reset mid transfer
        bs_arm(8'hAA, 1'b0);
        write_byte(8'h61);
        repeat (40) @(negedge clk);
        bs_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 abort busy", busy, 0);
        chk("R10 abort sck", sck_out, cfg_pol);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        chk("R10 no late done", done_flag, 0);
        chk("R10 no late byte", rx_valid, 0);

        // port off
        port_en = 1'b0;
        write_byte(8'h33);
        chk("R13 disabled ignores write", busy, 0);
        port_en = 1'b1;
        cfg_mode = 4'b0111;
        write_byte(8'h33);
        chk("R13 reserved mode ignores write", busy, 0);
        chk("R13 reserved mode no wcol", wcol_flag, 0);

        // slave without select, clock enable off
        cfg_mode = 4'b0101; sel_n = 1'b1; clk_en = 1'b0;
        repeat (4) @(negedge clk);
        exp_q.push_back(8'hA7);
        slave_bits(8'hA7, 0, 7);
        chk("R6 no done after 7 bits", done_flag, 0);
        slave_bits(8'hA7, 7, 8);
        repeat (4) @(negedge clk);
        chk("R7 slave done with clock gated", done_flag, 1);
        clk_en = 1'b1;
        clear_all();

        // slave with select
        cfg_mode = 4'b0100; sel_n = 1'b1;
        repeat (4) @(negedge clk);
        slave_bits(8'h3C, 0, 8);
        repeat (4) @(negedge clk);
        chk("R8 deselected no done", done_flag, 0);
        chk("R8 deselected no byte", rx_valid, 0);
        sel_n = 1'b0;
        repeat (4) @(negedge clk);
        exp_q.push_back(8'h5A);
        slave_bits(8'h5A, 0, 8);
        repeat (4) @(negedge clk);
        chk("R8 selected done", done_flag, 1);
        clear_all();

        chk("R3 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule